// File: doc/BRIEF.md
# Packet FIFO Rate Adapter

This block is a single-clock, per-port packet buffer placed between two Ethernet links of different speeds. Frames are written one word at a time with start, end, valid and a byte count for the final word. They are read out on the faster link's streaming interface only as whole frames. A frame is released only once its last word has been stored. After that it leaves as one burst with no holes in it, and a fixed idle gap follows each frame, so the read side sends exactly as many frames as it received.

A fill monitor watches occupancy, counted in words. It raises a `pause` output once occupancy rises above a high threshold, which defaults to half the depth. It keeps `pause` high until occupancy has dropped to a low threshold, which defaults to a quarter of the depth. The upstream sender uses `pause` to stretch its interframe gap.

If a word arrives while the buffer is full, the word is refused and a sticky overflow flag is set. The words of the unfinished frame are removed by rolling the write pointer back to that frame's first word. The rest of that frame, up to its end marker, is discarded.

Top module: `pkt_rate_adapter`

## Requirements
- R1: After reset, `out_valid`, `pause` and `overflow` are 0 and the buffer holds no words.
- R2: Stored frames leave in arrival order, and every word keeps its data, start bit, end bit and byte field. The byte field holds the number of valid bytes minus one.
- R3: `out_valid` stays 0 while no complete frame (a frame whose end-marked word has been accepted) is stored.
- R4: Once the first word of a frame has been transferred, `out_valid` stays 1 on every cycle until that frame's end-marked word has been transferred.
- R5: After an end-marked word is transferred, `out_valid` is 0 for exactly MIN_GAP cycles (default 2). It then returns to 1 if another complete frame is stored.
- R6: The number of end-marked words transferred out equals the number of complete frames accepted.
- R7: `pause` goes to 1 one cycle after occupancy (in words) is above HI_TH.
- R8: Once set, `pause` stays 1 until occupancy is at or below LO_TH, and it clears one cycle later.
- R9: A write that arrives while occupancy equals DEPTH is refused, and `overflow` rises the cycle after and stays 1 until reset.
- R10: On a refused write, the refused frame's stored words are removed and its remaining words up to and including its end-marked word are ignored. Later frames are stored normally.
- R11: While `out_ready` is 0, the output word and `out_valid` are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Write word valid |
| in_sop | input | 1 | Write word is first of frame |
| in_eop | input | 1 | Write word is last of frame |
| in_nbytes | input | BW | Valid bytes minus one (last word) |
| in_data | input | DATA_W | Write data |
| out_ready | input | 1 | Downstream accepts the word |
| out_valid | output | 1 | Read word valid |
| out_sop | output | 1 | Read word is first of frame |
| out_eop | output | 1 | Read word is last of frame |
| out_nbytes | output | BW | Valid bytes minus one |
| out_data | output | DATA_W | Read data |
| pause | output | 1 | Backpressure with hysteresis |
| overflow | output | 1 | Sticky write-refused flag |

## Verification
Long single frames written with a ready drain show whether readout waits for the end marker, stays gapless and inserts the idle gap. Random frame lengths with random valid and ready, and a sender that honours `pause`, exercise ordering, stalls and the two thresholds without overflowing. A phase with the drain held off fills the buffer past both thresholds into refusal. It separates a correct rollback of the unfinished frame from one that leaves a headless tail. A final drain then confirms that the frame counts match and that `pause` is released at the low mark.

// File: rtl/pfra_pkg.sv
`timescale 1ns/1ps
package pfra_pkg;
    // stored word layout, most significant first: sop, eop, nbytes, data
    function automatic int word_bits(input int data_w);
        return data_w + $clog2(data_w / 8) + 2;
    endfunction

    function automatic logic hyst_next(input logic cur, input logic above_hi,
                                       input logic at_or_below_lo);
        return cur ? !at_or_below_lo : above_hi;
    endfunction
endpackage

// File: rtl/pfra_store.sv
`timescale 1ns/1ps
module pfra_store #(
    parameter int DEPTH = 2048,
    parameter int WW    = 134,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_valid,
    input  logic [WW-1:0] wr_word,
    input  logic          rd_fire,
    output logic [WW-1:0] rd_word,
    output logic [AW:0]   used,
    output logic          pkts_nz,
    output logic          overflow
);
    logic [WW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   part_len, pkts;
    logic          dropping, full, acc, rej, wr_eop, rd_eop;

    assign wr_eop  = wr_word[WW-2];
    assign rd_word = mem[rd_ptr];
    assign rd_eop  = rd_word[WW-2];
    assign full    = (used == (AW+1)'(DEPTH));
    assign acc     = wr_valid && !dropping && !full;
    assign rej     = wr_valid && !dropping && full;
    assign pkts_nz = (pkts != '0);

    always_ff @(posedge clk) begin
        if (acc) mem[wr_ptr] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            used     <= '0;
            part_len <= '0;
            pkts     <= '0;
            dropping <= 1'b0;
            overflow <= 1'b0;
        end else begin
            if (acc) begin
                wr_ptr   <= wr_ptr + 1'b1;
                part_len <= wr_eop ? '0 : part_len + 1'b1;
            end
            if (rej) begin
                wr_ptr   <= wr_ptr - part_len[AW-1:0];
                part_len <= '0;
                overflow <= 1'b1;
                if (!wr_eop) dropping <= 1'b1;
            end
            if (dropping && wr_valid && wr_eop) dropping <= 1'b0;
            if (rd_fire) rd_ptr <= rd_ptr + 1'b1;
            used <= used + (AW+1)'(acc) - (AW+1)'(rd_fire) - (rej ? part_len : '0);
            pkts <= pkts + (AW+1)'(acc && wr_eop) - (AW+1)'(rd_fire && rd_eop);
        end
    end

    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);
    a_r9_refuse: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !dropping && used == (AW+1)'(DEPTH)) |=> overflow);
    a_r9_bound: assert property (@(posedge clk) disable iff (rst)
        used <= (AW+1)'(DEPTH));
    a_r3_whole: assert property (@(posedge clk) disable iff (rst)
        rd_fire |-> pkts != '0);
endmodule

// File: rtl/pfra_hyst.sv
`timescale 1ns/1ps
module pfra_hyst #(
    parameter int UW    = 12,
    parameter int HI_TH = 1024,
    parameter int LO_TH = 512
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [UW-1:0] used,
    output logic          pause
);
    localparam logic [UW-1:0] HI_V = UW'(HI_TH);
    localparam logic [UW-1:0] LO_V = UW'(LO_TH);

    always_ff @(posedge clk) begin
        if (rst) pause <= 1'b0;
        else     pause <= pfra_pkg::hyst_next(pause, used > HI_V, used <= LO_V);
    end

    a_r7_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(pause) |-> $past(used) > HI_V);
    a_r8_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(pause) |-> $past(used) <= LO_V);
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (pause && used > LO_V) |=> pause);
endmodule

// File: rtl/pfra_rdctl.sv
`timescale 1ns/1ps
module pfra_rdctl #(
    parameter int MIN_GAP = 2,
    localparam int GW     = (MIN_GAP < 1) ? 1 : $clog2(MIN_GAP + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic pkts_nz,
    input  logic word_eop,
    input  logic out_ready,
    output logic out_valid,
    output logic rd_fire
);
    logic [GW-1:0] gap_cnt;
    logic          mid;

    assign out_valid = pkts_nz && (gap_cnt == '0);
    assign rd_fire   = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_cnt <= '0;
            mid     <= 1'b0;
        end else begin
            if (rd_fire && word_eop) gap_cnt <= GW'(MIN_GAP);
            else if (gap_cnt != '0)  gap_cnt <= gap_cnt - 1'b1;
            if (rd_fire) mid <= !word_eop;
        end
    end

    a_r4_burst: assert property (@(posedge clk) disable iff (rst)
        mid |-> out_valid);
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid);
    generate
        if (MIN_GAP > 0) begin : g_gap_chk
            a_r5_gap: assert property (@(posedge clk) disable iff (rst)
                (rd_fire && word_eop) |=> !out_valid);
        end
    endgenerate
endmodule

// File: rtl/pkt_rate_adapter.sv
`timescale 1ns/1ps
module pkt_rate_adapter #(
    parameter int DATA_W  = 128,
    parameter int DEPTH   = 2048,
    parameter int HI_TH   = DEPTH / 2,
    parameter int LO_TH   = DEPTH / 4,
    parameter int MIN_GAP = 2,
    localparam int BW     = $clog2(DATA_W / 8),
    localparam int WW     = pfra_pkg::word_bits(DATA_W),
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [BW-1:0]     in_nbytes,
    input  logic [DATA_W-1:0] in_data,
    input  logic              out_ready,
    output logic              out_valid,
    output logic              out_sop,
    output logic              out_eop,
    output logic [BW-1:0]     out_nbytes,
    output logic [DATA_W-1:0] out_data,
    output logic              pause,
    output logic              overflow
);
    logic [WW-1:0] wr_word, rd_word;
    logic [AW:0]   used;
    logic          pkts_nz, rd_fire;

    assign wr_word = {in_sop, in_eop, in_nbytes, in_data};
    assign {out_sop, out_eop, out_nbytes, out_data} = rd_word;

    pfra_store #(.DEPTH(DEPTH), .WW(WW)) u_store (
        .clk(clk), .rst(rst), .wr_valid(in_valid), .wr_word(wr_word),
        .rd_fire(rd_fire), .rd_word(rd_word), .used(used),
        .pkts_nz(pkts_nz), .overflow(overflow)
    );

    pfra_rdctl #(.MIN_GAP(MIN_GAP)) u_rdctl (
        .clk(clk), .rst(rst), .pkts_nz(pkts_nz), .word_eop(out_eop),
        .out_ready(out_ready), .out_valid(out_valid), .rd_fire(rd_fire)
    );

    pfra_hyst #(.UW(AW + 1), .HI_TH(HI_TH), .LO_TH(LO_TH)) u_hyst (
        .clk(clk), .rst(rst), .used(used), .pause(pause)
    );
endmodule

// File: tb/sim_pkt_rate_adapter.sv
`timescale 1ns/1ps
module sim_pkt_rate_adapter;
    localparam int DATA_W = 32, DEPTH = 64, HI = 32, LO = 16, GAP = 2;
    localparam int BW = 2, WW = DATA_W + BW + 2;

    logic clk = 1'b0, rst = 1'b1;
    logic in_valid = 0, in_sop = 0, in_eop = 0, out_ready = 0;
    logic [BW-1:0] in_nbytes = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic out_valid, out_sop, out_eop, pause, overflow;
    logic [BW-1:0] out_nbytes;
    logic [DATA_W-1:0] out_data;

    always #2 clk = ~clk;

    pkt_rate_adapter #(.DATA_W(DATA_W), .DEPTH(DEPTH), .HI_TH(HI), .LO_TH(LO),
                       .MIN_GAP(GAP)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_nbytes(in_nbytes), .in_data(in_data),
        .out_ready(out_ready), .out_valid(out_valid), .out_sop(out_sop),
        .out_eop(out_eop), .out_nbytes(out_nbytes), .out_data(out_data),
        .pause(pause), .overflow(overflow)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    // reference model state
    logic [WW-1:0] mq[$];
    int m_pkts = 0, m_part = 0, m_gap = 0, in_pkts = 0, out_pkts = 0, n_rej = 0;
    bit m_drop = 0, m_pause = 0, m_ovf = 0, saw_pause = 0;

    // stimulus knobs
    int rdy_pct = 100, wr_pct = 100, g_fix = 0, g_max = 12, g_left = 0;
    bit gen_on = 0, obey = 0, g_sop = 0;

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_valid();
        return (m_pkts > 0) && (m_gap == 0);
    endfunction

    task automatic step();
        logic [WW-1:0] w, f;
        bit rdy, v, ev, full;
        @(negedge clk);
        ev = exp_valid();
        chk(out_valid == ev, "R3 R4 R5 out_valid", 64'(out_valid), 64'(ev));
        if (ev && out_valid)
            chk({out_sop, out_eop, out_nbytes, out_data} == mq[0], "R2 R11 word",
                64'({out_sop, out_eop, out_nbytes, out_data}), 64'(mq[0]));
        chk(pause == m_pause, "R7 R8 pause", 64'(pause), 64'(m_pause));
        chk(overflow == m_ovf, "R9 overflow", 64'(overflow), 64'(m_ovf));
        if (pause) saw_pause = 1;
        // choose inputs
        rdy = (($urandom % 100) < rdy_pct);
        v = 0;
        w = '0;
        if (g_left == 0 && gen_on && !(obey && pause)) begin
            g_left = (g_fix != 0) ? g_fix : 1 + int'($urandom % g_max);
            g_sop = 1;
        end
        if (g_left != 0 && (($urandom % 100) < wr_pct)) begin
            v = 1;
            w[WW-1] = g_sop;
            w[WW-2] = (g_left == 1);
            w[DATA_W +: BW] = w[WW-2] ? BW'($urandom) : '1;
            w[DATA_W-1:0] = $urandom;
            g_left--;
            g_sop = 0;
        end
        out_ready = rdy;
        in_valid = v;
        {in_sop, in_eop, in_nbytes, in_data} = w;
        if (out_valid && rdy && out_eop) out_pkts++;
        // model update for the coming edge
        full = (mq.size() == DEPTH);
        m_pause = m_pause ? !(mq.size() <= LO) : (mq.size() > HI);
        if (ev && rdy) begin
            f = mq.pop_front();
            if (f[WW-2]) begin m_pkts--; m_gap = GAP; end
            else if (m_gap > 0) m_gap--;
        end else if (m_gap > 0) m_gap--;
        if (v) begin
            if (m_drop) begin
                if (w[WW-2]) m_drop = 0;
            end else if (full) begin
                m_ovf = 1;
                n_rej++;
                repeat (m_part) void'(mq.pop_back());
                m_part = 0;
                if (!w[WW-2]) m_drop = 1;
            end else begin
                mq.push_back(w);
                if (w[WW-2]) begin m_part = 0; m_pkts++; in_pkts++; end
                else m_part++;
            end
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic drain(input int n);
        gen_on = 0;
        while (g_left != 0) step();
        rdy_pct = 100;
        run(n);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R6 watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(out_valid == 0, "R1 out_valid", 64'(out_valid), 0);
        chk(pause == 0, "R1 pause", 64'(pause), 0);
        chk(overflow == 0, "R1 overflow", 64'(overflow), 0);
        // R3 R4 R5: long frames, full-rate write and read
        g_fix = 20; gen_on = 1; rdy_pct = 100; wr_pct = 100;
        run(70);
        drain(40);
        // R2 R7 R8 R11: random traffic with a pause-obeying sender
        g_fix = 0; g_max = 12; rdy_pct = 70; wr_pct = 80; obey = 1; gen_on = 1;
        run(3000);
        // R9 R10: drain blocked, sender ignores pause
        obey = 0; rdy_pct = 0; wr_pct = 100;
        run(150);
        chk(saw_pause, "R7 pause seen", 64'(saw_pause), 1);
        chk(overflow == 1, "R9 overflow set", 64'(overflow), 1);
        chk(n_rej > 0, "R10 refusals", 64'(n_rej), 1);
        drain(200);
        chk(pause == 0, "R8 pause released", 64'(pause), 0);
        // mixed random after overflow
        obey = 1; rdy_pct = 50; wr_pct = 90; gen_on = 1;
        run(3000);
        drain(300);
        chk(mq.size() == 0 && out_valid == 0, "R10 empty after drain",
            64'(mq.size()), 0);
        chk(out_pkts == in_pkts, "R6 frame count", 64'(out_pkts), 64'(in_pkts));
        chk(overflow == 1, "R9 sticky", 64'(overflow), 1);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule